// File: doc/BRIEF.md
# Cascadable Serial Word Receiver

This block is the receive side of a converter's serial control port. A host frames each write by pulling an active-low frame select low. It then clocks data in on a serial clock, one bit per falling edge, most significant bit first. The block gathers the bits in a 24-bit shift register. When the frame select returns high, it hands the word and a one-cycle valid strobe to the register file. A frame that ends with too few bits is dropped.

The block can be chained with others of its kind. Once a frame has delivered more than 24 bits, the bits that leave the top of the register appear on the serial output, one per rising edge of the serial clock. That output feeds the serial input of the next device. A chain of n devices shares one frame select and one serial clock, and the host sends 24·n bits. The word meant for the farthest device goes first. When the frame select rises, each device keeps the last 24 bits it holds.

All serial inputs are brought into the local clock domain through synchronizer flops. Their edges are then detected in that domain. This works for a gated burst clock and for a free-running serial clock alike.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, the serial output, the parallel word and the valid strobe are all 0.
- R2: The serial input is sampled on each falling edge of the serial clock while the frame select is low. The first bit of a frame ends up in word bit 23 and the last in bit 0.
- R3: A frame with exactly 24 falling edges makes the word appear on the parallel output when the frame select rises. The valid strobe is high for exactly one local clock cycle at that time.
- R4: A frame with more than 24 falling edges latches only the last 24 bits received.
- R5: A frame with fewer than 24 falling edges produces no valid strobe and leaves the parallel word unchanged.
- R6: The shift register and the serial output are cleared when the frame select falls. The serial output changes only on rising edges of the serial clock inside a frame. Just before falling edge k of a frame (counting from 1), it shows the bit received on falling edge k-24, or 0 when k is 24 or less.
- R7: Serial clock edges while the frame select is high change neither the shift register, the serial output nor the parallel word.
- R8: Two devices chained output-to-input, given one 48-bit frame, each latch their own 24 bits: the far device the first 24 and the near device the last 24.
- R9: The parallel word holds its value in every cycle without a valid strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host or chain |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out toward the next device |
| word_o | output | 24 | Latched word for the register file |
| word_valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
Four properties are checked in every cycle. The valid strobe lasts a single cycle, and a short frame never produces one. The register and the serial output stay frozen outside frames and between serial clock rises, and the parallel word holds between strobes. Bit order and the selection of the last 24 bits from a long frame can only be shown by the bench's frames. So can the exact delay of bits through the serial output, and whether two chained devices split a 48-bit frame correctly; the bench compares these against a scoreboard.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned WORD_W_DEF      = 24;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  // Bit positions of the synchronized serial inputs
  localparam int unsigned IN_SCLK  = 0;
  localparam int unsigned IN_SYNC  = 1;
  localparam int unsigned IN_SDIN  = 2;
  localparam int unsigned IN_COUNT = 3;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = d;
      end else begin : g_rest
        assign stage_d[s] = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sfr_shift.sv
module sfr_shift #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              active,
  input  logic              sclk_fall,
  input  logic              sclk_rise,
  input  logic              din,
  output logic [WORD_W-1:0] shreg,
  output logic              sdo
);
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic              sdo_q, sdo_d;

  always_comb begin
    shreg_d = shreg_q;
    sdo_d   = sdo_q;
    if (clear) begin
      shreg_d = '0;
      sdo_d   = 1'b0;
    end else if (active) begin
      if (sclk_fall) shreg_d = {shreg_q[WORD_W-2:0], din};
      if (sclk_rise) sdo_d   = shreg_q[WORD_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      sdo_q   <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      sdo_q   <= sdo_d;
    end
  end

  assign shreg = shreg_q;
  assign sdo   = sdo_q;

  AST_SHIFT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clear) |=> $stable(shreg_q)); // R7
  AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !clear) |=> $stable(sdo_q)); // R6
endmodule

// File: rtl/sfr_frame.sv
module sfr_frame #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] shreg,
  output logic [WORD_W-1:0] word,
  output logic              valid
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;
  logic              full;

  assign full = (cnt_q == CNT_FULL);

  always_comb begin
    cnt_d   = cnt_q;
    word_d  = word_q;
    valid_d = 1'b0;
    if (frame_start)          cnt_d = '0;
    else if (shift_en && !full) cnt_d = cnt_q + 1'b1;
    if (frame_end && full) begin
      word_d  = shreg;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word  = word_q;
  assign valid = valid_q;

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R3
  AST_SHORT_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !full) |=> !valid_q); // R5
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(word_q)); // R9
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL); // R4
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int unsigned WORD_W      = sfr_pkg::WORD_W_DEF,
  parameter int unsigned SYNC_STAGES = sfr_pkg::SYNC_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdin,
  output logic              sdo,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  import sfr_pkg::*;

  localparam logic [IN_COUNT-1:0] IN_RST = IN_COUNT'((1 << IN_SCLK) | (1 << IN_SYNC));

  logic [IN_COUNT-1:0] raw_in, sync_in;
  logic                sclk_s, sync_s, sdin_s;
  logic                sclk_last_q, sync_last_q;
  logic                sclk_rise, sclk_fall, frame_start, frame_end, active;
  logic [WORD_W-1:0]   shreg;

  always_comb begin
    raw_in          = '0;
    raw_in[IN_SCLK] = sclk;
    raw_in[IN_SYNC] = sync_n;
    raw_in[IN_SDIN] = sdin;
  end

  sfr_sync #(.WIDTH(IN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );

  assign sclk_s = sync_in[IN_SCLK];
  assign sync_s = sync_in[IN_SYNC];
  assign sdin_s = sync_in[IN_SDIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_last_q <= 1'b1;
      sync_last_q <= 1'b1;
    end else begin
      sclk_last_q <= sclk_s;
      sync_last_q <= sync_s;
    end
  end

  assign sclk_rise   = sclk_s & ~sclk_last_q;
  assign sclk_fall   = ~sclk_s & sclk_last_q;
  assign frame_start = ~sync_s & sync_last_q;
  assign frame_end   = sync_s & ~sync_last_q;
  assign active      = ~sync_s;

  sfr_shift #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .active(active),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .din(sdin_s),
    .shreg(shreg), .sdo(sdo)
  );

  sfr_frame #(.WORD_W(WORD_W)) i_frame (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .shift_en(active & sclk_fall), .shreg(shreg),
    .word(word_o), .valid(word_valid_o)
  );
endmodule

// File: tb/test_serial_frame_rx.sv
module test_serial_frame_rx;
  localparam int W = 24;

  logic clk, rst_n, sclk, sync_n, sdin;
  logic sdo_a, sdo_b, valid_a, valid_b;
  logic [W-1:0] word_a, word_b;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_a[$], exp_b[$];
  string        req_a[$], req_b[$];
  logic [W-1:0] last_a = '0;

  serial_frame_rx i_serial_frame_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .sdo(sdo_a), .word_o(word_a), .word_valid_o(valid_a)
  );

  serial_frame_rx i_serial_frame_rx_far (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdo_a),
    .sdo(sdo_b), .word_o(word_b), .word_valid_o(valid_b)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n && valid_a) begin
      if (exp_a.size() == 0) check(1'b0, "R5 near: unexpected strobe", word_a, '0);
      else begin
        logic [W-1:0] e; string r;
        e = exp_a.pop_front(); r = req_a.pop_front();
        check(word_a == e, r, word_a, e);
        last_a = e;
      end
    end
    if (rst_n && valid_b) begin
      if (exp_b.size() == 0) check(1'b0, "R5 far: unexpected strobe", word_b, '0);
      else begin
        logic [W-1:0] e; string r;
        e = exp_b.pop_front(); r = req_b.pop_front();
        check(word_b == e, r, word_b, e);
      end
    end
  end

  // Driver: bits[n-1] is sent first; bits above n-1 must be zero
  task automatic send_frame(input logic [95:0] bits, input int n, input string req);
    sync_n = 1'b0;
    #100;
    for (int i = 0; i < n; i++) begin
      sdin = bits[n-1-i];
      #50;
      check(sdo_a == ((i < W) ? 1'b0 : bits[n+W-1-i]), "R6 sdo delay",
            {{(W-1){1'b0}}, sdo_a}, {{(W-1){1'b0}}, ((i < W) ? 1'b0 : bits[n+W-1-i])});
      sclk = 1'b0;
      #50;
      sclk = 1'b1;
    end
    #100;
    if (n >= W) begin
      exp_a.push_back(bits[W-1:0]);    req_a.push_back(req);
      exp_b.push_back(bits[2*W-1:W]);  req_b.push_back(req);
    end
    sync_n = 1'b1;
    #200;
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b1; sync_n = 1'b1; sdin = 1'b0;
    #52;
    @(negedge clk) rst_n = 1'b1;
    #30;
    check(sdo_a == 1'b0, "R1 sdo", {{(W-1){1'b0}}, sdo_a}, '0);
    check(word_a == '0, "R1 word", word_a, '0);
    check(valid_a == 1'b0, "R1 valid", {{(W-1){1'b0}}, valid_a}, '0);

    send_frame(96'h800000, W, "R2 first bit lands in bit 23");
    send_frame(96'hA5C3E1, W, "R3 exact 24-bit frame");
    send_frame(96'h3F_5A1B2C, 30, "R4 last 24 of 30 bits");

    send_frame(96'h2AB, 10, "R5 short frame");
    check(word_a == last_a, "R5 word unchanged after short frame", word_a, last_a);
    check(valid_a == 1'b0, "R5 no strobe", {{(W-1){1'b0}}, valid_a}, '0);

    begin
      logic s0;
      s0 = sdo_a;
      for (int k = 0; k < 40; k++) begin
        sdin = k[1] ^ k[0];
        #50 sclk = 1'b0;
        #50 sclk = 1'b1;
      end
      #100;
      check(word_a == last_a, "R7 idle clocks ignored (word)", word_a, last_a);
      check(sdo_a == s0, "R7 idle clocks ignored (sdo)", {{(W-1){1'b0}}, sdo_a}, {{(W-1){1'b0}}, s0});
      check(word_a == last_a, "R9 word held between strobes", word_a, last_a);
    end

    send_frame(96'h13579B_2468AC, 2*W, "R8 two-device chain");
    send_frame(96'hFEDCBA, W, "R3 second exact frame");

    #500;
    check(exp_a.size() == 0, "R3 near strobes all seen", W'(exp_a.size()), '0);
    check(exp_b.size() == 0, "R8 far strobes all seen", W'(exp_b.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule